// File: doc/BRIEF.md
# Two-Tier Slot Bus Arbiter

This block decides which of five bus requesters owns a shared bus. Each requester has its own request input and grant output. Slots 0 and 1 are devices built into the board and slots 2 to 4 are plug-in positions. A software-written mask places every slot in either an urgent tier or a background tier. An urgent request always beats a background request.

Among urgent requesters the highest-numbered slot wins. Background requesters take turns through a rotating pointer. The pointer points one past the last background slot that won. Once a grant is given it is held until the bus goes idle or its owner withdraws its request. A mask write is applied at the next decision, so a transfer in progress is never cut short.

Top module: `arb_two_tier`

## Requirements
- R1: At most one bit of `gnt` is high in any cycle.
- R2: While `rst_n` is low, `gnt` is all zero, every slot is in the background tier (mask all zero) and the rotation pointer is at slot 0.
- R3: When no `req` bit is high at a clock edge, `gnt` is all zero after that edge.
- R4: The current owner keeps its grant, unchanged, across every edge where its `req` bit is high and `bus_idle` is low.
- R5: At a decision edge, if any urgent-tier slot requests, the grant after the edge goes to an urgent-tier slot. A decision edge is one where there is no owner, or `bus_idle` is high, or the owner's `req` is low.
- R6: Among urgent-tier requesters the one with the largest slot number is granted.
- R7: With no urgent request, the grant goes to the first background requester found by searching upward from the pointer, wrapping from slot 4 to slot 0. After the edge the pointer moves to the slot after the winner.
- R8: The pointer moves only when a background slot is granted. Urgent grants and held grants leave it unchanged.
- R9: A high `grp_wr_en` at an edge loads `grp_wr_data` into the mask; bit i high puts slot i in the urgent tier. The new mask is first used at the next decision edge after the write. It neither displaces nor affects a grant that is being held.
- R10: The grant is registered. The decision taken from the inputs at an edge appears on `gnt` just after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 5 | Bus request, one bit per slot |
| bus_idle | input | 1 | High when no transfer is running on the bus |
| grp_wr_en | input | 1 | Write strobe for the tier mask |
| grp_wr_data | input | 5 | New tier mask, bit high = urgent tier |
| gnt | output | 5 | Bus grant, one-hot or zero |

## Verification
Two functions can fall in the same cycle: a mask write and an arbitration decision. The bench provokes this by writing the mask on the same edge where the bus is idle and several slots request. It expects the winner to follow the old mask and the next decision to follow the new one. A write made while an owner holds the bus against urgent competitors is also checked: the grant must stay put. A second collision, a background grant against a pointer that wraps, is driven with all five slots requesting on every idle edge. The rotation is then compared slot by slot.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int ARB_NSLOT = 5;

  // index one above i, wrapping at n
  function automatic int unsigned arb_wrap_inc(input int unsigned i, input int unsigned n);
    return (i + 1 >= n) ? 0 : i + 1;
  endfunction
endpackage

// File: rtl/arb_grp_reg.sv
module arb_grp_reg #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] wr_data,
  output logic [N-1:0] grp
);
  logic [N-1:0] grp_d;

  always_comb begin
    grp_d = grp;
    if (wr_en) grp_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grp <= '0;
    else        grp <= grp_d;
  end
endmodule

// File: rtl/arb_fixed_pick.sv
module arb_fixed_pick #(
  parameter int N = 5
) (
  input  logic [N-1:0] vec,
  output logic         any,
  output logic [N-1:0] oh
);
  always_comb begin
    oh = '0;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) begin
        oh    = '0;
        oh[i] = 1'b1;
      end
    end
    any = |vec;
  end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N  = 5,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  input  logic [IW-1:0] ptr,
  output logic          any,
  output logic [N-1:0]  oh,
  output logic [IW-1:0] idx
);
  always_comb begin
    int unsigned pos;
    logic        found;
    oh    = '0;
    idx   = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      pos = int'(ptr) + k;
      if (pos >= N) pos = pos - N;
      if (!found && vec[pos]) begin
        found   = 1'b1;
        oh[pos] = 1'b1;
        idx     = IW'(pos);
      end
    end
    any = found;
  end
endmodule

// File: rtl/arb_two_tier.sv
module arb_two_tier #(
  parameter int N = arb_pkg::ARB_NSLOT,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         bus_idle,
  input  logic         grp_wr_en,
  input  logic [N-1:0] grp_wr_data,
  output logic [N-1:0] gnt
);
  logic [N-1:0]  grp_q;
  logic [N-1:0]  gnt_q, gnt_d;
  logic [IW-1:0] ptr_q, ptr_d;
  logic          hi_any, lo_any, rearb, lo_win;
  logic [N-1:0]  hi_oh, lo_oh;
  logic [IW-1:0] lo_idx;

  arb_grp_reg #(.N(N)) u_grp (
    .clk(clk), .rst_n(rst_n), .wr_en(grp_wr_en),
    .wr_data(grp_wr_data), .grp(grp_q)
  );

  arb_fixed_pick #(.N(N)) u_hi (
    .vec(req & grp_q), .any(hi_any), .oh(hi_oh)
  );

  arb_rr_pick #(.N(N)) u_lo (
    .vec(req & ~grp_q), .ptr(ptr_q), .any(lo_any), .oh(lo_oh), .idx(lo_idx)
  );

  // decision edge: no owner, bus idle, or owner withdrew
  assign rearb  = (gnt_q == '0) || bus_idle || ((gnt_q & req) == '0);
  assign lo_win = rearb && !hi_any && lo_any;

  always_comb begin
    gnt_d = gnt_q;
    ptr_d = ptr_q;
    if (rearb) gnt_d = hi_any ? hi_oh : lo_oh;
    if (lo_win) ptr_d = IW'(arb_pkg::arb_wrap_inc(int'(lo_idx), N));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q <= '0;
      ptr_q <= '0;
    end else begin
      gnt_q <= gnt_d;
      ptr_q <= ptr_d;
    end
  end

  assign gnt = gnt_q;
endmodule

// File: rtl/arb_two_tier_chk.sv
module arb_two_tier_chk #(
  parameter int N = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req,
  input logic         bus_idle,
  input logic [N-1:0] grp,
  input logic [N-1:0] gnt
);
  logic decide;
  assign decide = (gnt == '0) || bus_idle || ((gnt & req) == '0);

  assert_onehot_gnt_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  assert_idle_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> (gnt == '0));

  assert_hold_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (((gnt & req) != '0) && !bus_idle) |=> $stable(gnt));

  assert_urgent_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && ((req & grp) != '0)) |=> ((gnt & $past(req) & $past(grp)) != '0));

  // R10: a decision with any request grants a requester
  assert_grant_requester_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && (req != '0)) |=> ((gnt & $past(req)) != '0));
endmodule

bind arb_two_tier arb_two_tier_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .bus_idle(bus_idle),
  .grp(grp_q), .gnt(gnt)
);

// File: tb/arb_two_tier_test.sv
module arb_two_tier_test;
  localparam int N = 5;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         bus_idle = 1'b0;
  logic         grp_wr_en = 1'b0;
  logic [N-1:0] grp_wr_data = '0;
  logic [N-1:0] gnt;

  int vectors = 0;
  int errors  = 0;
  string tag = "R2";

  // behavioural reference state
  int       m_owner = -1;
  int       m_ptr   = 0;
  bit [4:0] m_grp   = '0;

  arb_two_tier uut (
    .clk(clk), .rst_n(rst_n), .req(req), .bus_idle(bus_idle),
    .grp_wr_en(grp_wr_en), .grp_wr_data(grp_wr_data), .gnt(gnt)
  );

  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_owner = -1; m_ptr = 0; m_grp = '0;
    end else begin
      bit redo;
      int win;
      redo = (m_owner < 0) || bus_idle || !req[m_owner];
      if (redo) begin
        win = -1;
        for (int s = N - 1; s >= 0; s--)
          if (win < 0 && req[s] && m_grp[s]) win = s;
        if (win < 0) begin
          for (int k = 0; k < N; k++) begin
            int s;
            s = (m_ptr + k) % N;
            if (win < 0 && req[s] && !m_grp[s]) win = s;
          end
          if (win >= 0) m_ptr = (win + 1) % N;
        end
        m_owner = win;
      end
      if (grp_wr_en) m_grp = grp_wr_data;
    end
  end

  function automatic logic [N-1:0] exp_gnt();
    logic [N-1:0] v;
    v = '0;
    if (m_owner >= 0) v[m_owner] = 1'b1;
    return v;
  endfunction

  task automatic check_now();
    vectors++;
    if (gnt !== exp_gnt()) begin
      errors++;
      $display("FAIL %s: gnt actual %b expected %b at %0t", tag, gnt, exp_gnt(), $time);
    end
    if ($countones(gnt) > 1) begin
      errors++;
      $display("FAIL R1: gnt actual %b expected at most one bit", gnt);
    end
  endtask

  // advance one cycle with given inputs, then compare
  task automatic step(input logic [N-1:0] r, input logic idle,
                      input logic we, input logic [N-1:0] wd);
    req = r; bus_idle = idle; grp_wr_en = we; grp_wr_data = wd;
    @(negedge clk);
    check_now();
  endtask

  task automatic expect_slot(input int s, input string t);
    vectors++;
    if (gnt !== (5'b1 << s)) begin
      errors++;
      $display("FAIL %s: gnt actual %b expected %b", t, gnt, 5'b1 << s);
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    tag = "R2";
    repeat (3) @(negedge clk);
    check_now();
    rst_n = 1'b1;
    @(negedge clk); check_now();

    // R7: all background, every edge a decision, rotation 0..4 wrapping
    tag = "R7";
    for (int i = 0; i < 6; i++) begin
      step(5'b11111, 1'b1, 1'b0, '0);
      expect_slot(i % N, "R7");
    end
    // pointer now after slot 0 -> slot 1 next

    // R9: write mask on a decision edge; old mask governs this decision
    tag = "R9";
    step(5'b11111, 1'b1, 1'b1, 5'b10100);
    expect_slot(1, "R9");
    // R5 R6: urgent slots 2 and 4, slot 4 wins
    tag = "R6";
    step(5'b11111, 1'b1, 1'b0, '0);
    expect_slot(4, "R6");
    step(5'b00111, 1'b1, 1'b0, '0);
    expect_slot(2, "R5");
    // R8: urgent grants left pointer at slot 2 -> next background from 2 is 3? slot 2 urgent, so 3
    tag = "R8";
    step(5'b01011, 1'b1, 1'b0, '0);
    expect_slot(3, "R8");
    step(5'b00011, 1'b1, 1'b0, '0);
    expect_slot(0, "R8");

    // R4: owner holds while bus busy against an urgent competitor
    tag = "R4";
    step(5'b00010, 1'b1, 1'b0, '0);
    expect_slot(1, "R4");
    for (int i = 0; i < 4; i++) begin
      step(5'b10010, 1'b0, (i == 1), 5'b00010);
      expect_slot(1, "R4");
    end
    // R9: new mask (only slot 1 urgent) used once bus goes idle
    tag = "R9";
    step(5'b10010, 1'b1, 1'b0, '0);
    expect_slot(1, "R9");
    // owner drops -> slot 4 (now background) gets it
    step(5'b10000, 1'b0, 1'b0, '0);
    expect_slot(4, "R9");

    // R3: no requests clears the grant
    tag = "R3";
    step(5'b00000, 1'b0, 1'b0, '0);
    vectors++;
    if (gnt !== '0) begin
      errors++;
      $display("FAIL R3: gnt actual %b expected 00000", gnt);
    end
    step(5'b00000, 1'b1, 1'b0, '0);

    // R10 and mixed traffic against the reference model
    tag = "R10";
    for (int i = 0; i < 400; i++) begin
      logic [N-1:0] r, d;
      logic id, we;
      r  = N'($urandom);
      id = ($urandom % 3) == 0;
      we = ($urandom % 17) == 0;
      d  = N'($urandom);
      step(r, id, we, d);
    end

    // R2: asynchronous reset mid-run
    tag = "R2";
    step(5'b11111, 1'b1, 1'b0, '0);
    #1 rst_n = 1'b0;
    #1;
    vectors++;
    if (gnt !== '0) begin
      errors++;
      $display("FAIL R2: gnt actual %b expected 00000", gnt);
    end
    @(negedge clk); rst_n = 1'b1;
    step(5'b11111, 1'b1, 1'b0, '0);
    expect_slot(0, "R2");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule